// File: doc/BRIEF.md
# Branch History Table Predictor

This block predicts branches for an instruction fetch unit. It is a small direct-mapped table indexed by the low bits of a branch's instruction address. Each entry holds a tag, the last taken target of that branch and a two-bit direction state. The fetch stage gives the current fetch address. In the same cycle, without a clock edge, it receives a hit flag, a taken/not-taken guess and the address to fetch next. That next address is the stored target when the guess is taken and the next sequential word otherwise.

The execute stage reports each resolved branch. It gives the branch address, the real direction, the real target and the next address that fetch actually used after that branch. The block compares that address with the correct one. When they differ, it raises a flush together with the address where fetch must restart. On the following clock edge the table learns from the outcome. It allocates the entry on a miss, or steps the entry's direction state on a hit.

Top module: `branch_history_predictor`

## Requirements
- R1: Reset (synchronous, active low) invalidates every entry, so the first lookup after reset misses.
- R2: A lookup that misses gives hit=0, taken=0 and a next address of fetch_pc+4. A lookup misses when the entry at its index is invalid or its tag differs.
- R3: A resolved branch that misses allocates its entry. The entry gets the branch's tag and target and starts in the weak state of the real outcome, so it predicts that outcome on the next lookup.
- R4: A hit in a taken state gives taken=1 and the stored target as the next address. A hit in a not-taken state gives taken=0 and fetch_pc+4. A taken outcome on a hit replaces the stored target.
- R5: From a strong state, one outcome against the prediction moves the entry to the weak state of the same prediction, so the prediction does not change.
- R6: A second contrary outcome in a row, from the weak state, flips the prediction.
- R7: An outcome that agrees with the prediction moves a weak state to the strong state of the same prediction.
- R8: Two branches that share an index but differ in tag evict each other. The newer one replaces the older, and the older one then misses.
- R9: The correct next address is res_target when the branch was taken and res_pc+4 otherwise. When a valid result's res_pred_next differs from that address, flush=1 and flush_pc is set to it in the same cycle. When they match, flush=0.
- R10: A lookup and an update of the same entry in the same cycle return the entry's contents from before the update.
- R11: With res_valid=0 the table is unchanged and flush stays 0, whatever the other result inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| fetch_hit | output | 1 | Lookup found a matching valid entry |
| fetch_taken | output | 1 | Predicted direction (1 = taken) |
| fetch_next_pc | output | ADDR_W | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Real direction of the branch |
| res_target | input | ADDR_W | Real target of the branch |
| res_pred_next | input | ADDR_W | Next address fetch used after the branch |
| flush | output | 1 | Misprediction: discard younger work |
| flush_pc | output | ADDR_W | Correct restart address |

## Verification
The hardest situation to reach is the difference between a strong state and a weak state of the same direction. Both give the same prediction, so one lookup cannot tell them apart. The bench therefore applies a series of agreeing and contrary outcomes to one branch. It then reads the prediction after each contrary outcome: one contrary outcome must leave the prediction unchanged only if the agreeing outcome before it reached the strong state. The same-cycle read-before-write case is reached by presenting a lookup and an allocating result for the same branch in the same cycle. Eviction is reached by using an address that lies exactly one table span away from an existing branch.

// File: rtl/bht_pkg.sv
// Shared types for the branch history table predictor.
// Assumes: the MSB of the state encoding is the predicted direction.
package bht_pkg;

    typedef enum logic [1:0] {
        ST_NT_STRONG = 2'b00,
        ST_NT_WEAK   = 2'b01,
        ST_T_WEAK    = 2'b10,
        ST_T_STRONG  = 2'b11
    } pred_state_e;

    // Direction predicted by a state.
    function automatic logic state_is_taken(input pred_state_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/bht_counter.sv
// Next-state function of the two-bit direction machine.
// Hit: saturating step toward the real outcome.
// Miss: weak state of the real outcome (new allocation).
// Assumes: purely combinational; the caller registers the result.
module bht_counter
    import bht_pkg::*;
(
    input  logic        hit,
    input  pred_state_e cur_st,
    input  logic        taken,
    output pred_state_e nxt_st
);

    // Choose the state to write back for this outcome.
    always_comb begin
        if (!hit) begin
            nxt_st = taken ? ST_T_WEAK : ST_NT_WEAK;
        end else begin
            unique case (cur_st)
                ST_NT_STRONG: nxt_st = taken ? ST_NT_WEAK  : ST_NT_STRONG;
                ST_NT_WEAK:   nxt_st = taken ? ST_T_WEAK   : ST_NT_STRONG;
                ST_T_WEAK:    nxt_st = taken ? ST_T_STRONG : ST_NT_WEAK;
                default:      nxt_st = taken ? ST_T_STRONG : ST_T_WEAK;
            endcase
        end
    end

endmodule

// File: rtl/bht_table.sv
// Direct-mapped storage: valid bit, tag, target and state per entry.
// Two combinational read ports (fetch side, resolve side), one write port.
// Writes land on the clock edge, so reads in the write cycle see old data.
// Assumes: synchronous active-low reset clears valid bits only.
module bht_table
    import bht_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // fetch-side read
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_tgt,
    output pred_state_e       rd_st,
    // resolve-side read
    input  logic [IDX_W-1:0]  up_idx,
    output logic              up_valid,
    output logic [TAG_W-1:0]  up_tag,
    output logic [ADDR_W-1:0] up_tgt,
    output pred_state_e       up_st,
    // write
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  pred_state_e       wr_st
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    pred_state_e        st_q  [ENTRIES];

    // Clear valid bits on reset; otherwise write one entry per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            tgt_q[wr_idx]   <= wr_tgt;
            st_q[wr_idx]    <= wr_st;
        end
    end

    // Fetch-side read port.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
        rd_st    = st_q[rd_idx];
    end

    // Resolve-side read port.
    always_comb begin
        up_valid = valid_q[up_idx];
        up_tag   = tag_q[up_idx];
        up_tgt   = tgt_q[up_idx];
        up_st    = st_q[up_idx];
    end

    // A write leaves its entry valid, carrying the written tag and state.
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
                  && st_q[$past(wr_idx)] == $past(wr_st)); // R3

endmodule

// File: rtl/bht_resolve.sv
// Works out the correct next address for a resolved branch and flags a
// misprediction when the address fetch actually used differs from it.
// Assumes: addresses advance by STEP bytes per instruction.
module bht_resolve #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic [ADDR_W-1:0] res_pred_next,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_pc
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] right_next;

    // Correct successor of the branch and the flush decision.
    always_comb begin
        right_next = res_taken ? res_target : res_pc + STEP_V;
        flush      = res_valid && (res_pred_next != right_next);
        flush_pc   = right_next;
    end

endmodule

// File: rtl/branch_history_predictor.sv
// Branch history table predictor top.
// Fetch side: combinational lookup of fetch_pc -> hit, direction, next pc.
// Resolve side: one resolved branch per cycle; allocates on miss, steps the
// direction machine on hit, and flags a flush with the restart address.
// Assumes: instructions are 2**ALIGN_W bytes and aligned.
module branch_history_predictor
    import bht_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int ALIGN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_hit,
    output logic              fetch_taken,
    output logic [ADDR_W-1:0] fetch_next_pc,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic [ADDR_W-1:0] res_pred_next,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_pc
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;
    localparam int STEP  = 1 << ALIGN_W;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [IDX_W-1:0]  f_idx, u_idx;
    logic [TAG_W-1:0]  f_tag, u_tag;
    logic              f_valid, u_valid;
    logic [TAG_W-1:0]  f_stag, u_stag;
    logic [ADDR_W-1:0] f_tgt, u_tgt;
    pred_state_e       f_st, u_st, nxt_st;
    logic              u_hit;
    logic [ADDR_W-1:0] wr_tgt;

    // Split addresses into index and tag.
    always_comb begin
        f_idx = fetch_pc[ALIGN_W +: IDX_W];
        f_tag = fetch_pc[ADDR_W-1 -: TAG_W];
        u_idx = res_pc[ALIGN_W +: IDX_W];
        u_tag = res_pc[ADDR_W-1 -: TAG_W];
    end

    bht_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_valid (f_valid),
        .rd_tag   (f_stag),
        .rd_tgt   (f_tgt),
        .rd_st    (f_st),
        .up_idx   (u_idx),
        .up_valid (u_valid),
        .up_tag   (u_stag),
        .up_tgt   (u_tgt),
        .up_st    (u_st),
        .wr_en    (res_valid),
        .wr_idx   (u_idx),
        .wr_tag   (u_tag),
        .wr_tgt   (wr_tgt),
        .wr_st    (nxt_st)
    );

    // Fetch-side prediction from the looked-up entry.
    always_comb begin
        fetch_hit     = f_valid && (f_stag == f_tag);
        fetch_taken   = fetch_hit && state_is_taken(f_st);
        fetch_next_pc = fetch_taken ? f_tgt : fetch_pc + STEP_V;
    end

    // Resolve-side hit and the target to write back.
    always_comb begin
        u_hit  = u_valid && (u_stag == u_tag);
        wr_tgt = (u_hit && !res_taken) ? u_tgt : res_target;
    end

    bht_counter counter_i (
        .hit    (u_hit),
        .cur_st (u_st),
        .taken  (res_taken),
        .nxt_st (nxt_st)
    );

    bht_resolve #(
        .ADDR_W (ADDR_W),
        .STEP   (STEP)
    ) resolve_i (
        .res_valid     (res_valid),
        .res_pc        (res_pc),
        .res_taken     (res_taken),
        .res_target    (res_target),
        .res_pred_next (res_pred_next),
        .flush         (flush),
        .flush_pc      (flush_pc)
    );

    AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fetch_hit); // R1

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_hit |-> !fetch_taken && fetch_next_pc == fetch_pc + STEP_V); // R2

    AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !u_hit |-> (nxt_st == ST_T_WEAK || nxt_st == ST_NT_WEAK)
                                && state_is_taken(nxt_st) == res_taken); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && u_hit |-> (nxt_st == u_st) || (3'(nxt_st) == 3'(u_st) + 3'd1)
                               || (3'(u_st) == 3'(nxt_st) + 3'd1)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !flush); // R11

endmodule

// File: tb/branch_history_predictor_tb_top.sv
module branch_history_predictor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          fetch_hit, fetch_taken;
    logic [AW-1:0] fetch_next_pc;
    logic          res_valid = 1'b0;
    logic [AW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic [AW-1:0] res_target = '0;
    logic [AW-1:0] res_pred_next = '0;
    logic          flush;
    logic [AW-1:0] flush_pc;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic          hit;
        logic          taken;
        logic [AW-1:0] next;
        logic          fl;
        logic [AW-1:0] fpc;
        string         req;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_history_predictor dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_pc      (fetch_pc),
        .fetch_hit     (fetch_hit),
        .fetch_taken   (fetch_taken),
        .fetch_next_pc (fetch_next_pc),
        .res_valid     (res_valid),
        .res_pc        (res_pc),
        .res_taken     (res_taken),
        .res_target    (res_target),
        .res_pred_next (res_pred_next),
        .flush         (flush),
        .flush_pc      (flush_pc)
    );

    // Driver: apply one cycle of stimulus and push its expected outputs.
    task automatic drive(input logic [AW-1:0] lpc, input logic uv, input logic [AW-1:0] upc,
                         input logic ut, input logic [AW-1:0] utg, input logic [AW-1:0] upn,
                         input logic eh, input logic et, input logic [AW-1:0] en,
                         input logic ef, input logic [AW-1:0] efp, input string req);
        exp_t e;
        fetch_pc      = lpc;
        res_valid     = uv;
        res_pc        = upc;
        res_taken     = ut;
        res_target    = utg;
        res_pred_next = upn;
        e.hit = eh; e.taken = et; e.next = en; e.fl = ef; e.fpc = efp; e.req = req;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // Lookup only, no resolved branch.
    task automatic look(input logic [AW-1:0] lpc, input logic eh, input logic et,
                        input logic [AW-1:0] en, input string req);
        drive(lpc, 1'b0, '0, 1'b0, '0, '0, eh, et, en, 1'b0, '0, req);
    endtask

    // Monitor: compare outputs mid-cycle against the scoreboard head.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (fetch_hit !== e.hit || fetch_taken !== e.taken || fetch_next_pc !== e.next ||
                flush !== e.fl || (e.fl && flush_pc !== e.fpc)) begin
                n_errors++;
                $display("FAIL %s: got hit=%b tk=%b next=%h flush=%b fpc=%h, exp hit=%b tk=%b next=%h flush=%b fpc=%h",
                         e.req, fetch_hit, fetch_taken, fetch_next_pc, flush, flush_pc,
                         e.hit, e.taken, e.next, e.fl, e.fpc);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        res_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    localparam logic [AW-1:0] A  = 32'h0000_0100; // index 0
    localparam logic [AW-1:0] B  = 32'h0000_0140; // index 0, other tag
    localparam logic [AW-1:0] C  = 32'h0000_0020; // index 8
    localparam logic [AW-1:0] T1 = 32'h0000_0400;
    localparam logic [AW-1:0] T2 = 32'h0000_0800;
    localparam logic [AW-1:0] T3 = 32'h0000_0900;

    initial begin
        do_reset();
        look(A, 0, 0, A+4, "R1 empty after reset");
        look(C, 0, 0, C+4, "R2 miss gives sequential");
        // allocate A taken; fetch had used A+4 -> flush to T1; same-cycle lookup sees old
        drive(A, 1, A, 1, T1, A+4, 0, 0, A+4, 1, T1, "R10 R9 alloc with same-cycle lookup");
        look(A, 1, 1, T1, "R3 R4 allocated weak taken");
        drive(A, 1, A, 1, T1, T1, 1, 1, T1, 0, '0, "R9 correct prediction no flush");
        look(A, 1, 1, T1, "R7 strong taken");
        drive(C, 1, A, 0, T1, T1, 0, 0, C+4, 1, A+4, "R9 flush to sequential");
        look(A, 1, 1, T1, "R5 R7 strong->weak keeps taken");
        drive(C, 1, A, 0, T1, T1, 0, 0, C+4, 1, A+4, "R9 second contrary");
        look(A, 1, 0, A+4, "R6 flipped to not taken");
        drive(A, 1, A, 0, T1, A+4, 1, 0, A+4, 0, '0, "R9 R10 agreeing not taken");
        look(A, 1, 0, A+4, "R7 strong not taken");
        drive(C, 1, A, 1, T2, A+4, 0, 0, C+4, 1, T2, "R9 taken against strong NT");
        look(A, 1, 0, A+4, "R5 strong NT->weak NT");
        drive(C, 1, A, 1, T2, A+4, 0, 0, C+4, 1, T2, "R9 second taken");
        look(A, 1, 1, T2, "R6 R4 flipped to taken new target");
        drive(A, 0, A, 0, T3, 32'hDEAD_BEEC, 1, 1, T2, 0, '0, "R11 invalid result no flush");
        look(A, 1, 1, T2, "R11 table unchanged");
        look(B, 0, 0, B+4, "R8 alias tag misses");
        drive(C, 1, B, 0, T3, B+4, 0, 0, C+4, 0, '0, "R9 R8 alias alloc not taken");
        look(B, 1, 0, B+4, "R3 R8 alias weak not taken");
        look(A, 0, 0, A+4, "R8 evicted branch misses");
        look(C, 0, 0, C+4, "R2 untouched index still misses");
        do_reset();
        look(B, 0, 0, B+4, "R1 reset mid-run clears entries");
        @(posedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule